// File: doc/BRIEF.md
# Accelerator Job Dispatcher

This block is the front end of a block-cipher accelerator. Each start pulse brings in one job descriptor: a 32-bit control flag word, an input byte address, an output byte address, a byte count and a mode. A flag word of zero is a discovery request. The block then loads its type code and release level into two configuration registers and answers at once with a fixed completion code. Any other flag word runs a job. The job is one of three: load a key, encrypt or decrypt. For a job the block reads host memory, drives an external key-expansion sequencer or an external block-cipher engine, and writes the results back. It then reports a completion code.

Host memory is reached through two independent 512-bit channels, one for reads and one for writes. Both channels are addressed by word index, which is the byte address with its six low bits dropped. The byte offset inside the fetched word selects the data wanted. Cipher blocks are 8 bytes. Results are collected into a 64-byte output word and written only when that word is finished or the job ends. The cipher engine and the key sequencer each sit behind a one-cycle start pulse and a done pulse.

Top module: `acc_job_dispatch`

## Requirements
- R1: When `start` is seen in idle with `flags` equal to 0, `cfg_type` and `cfg_rev` load the TYPE_CODE and REL_LEVEL parameters. `retc` becomes 32'hE00F and `done` pulses on the following clock edge. This holds whatever the mode is.
- R2: A nonzero `flags` value runs a job selected by `mode`: 0 loads a key, 1 encrypts, 2 decrypts. Any other mode returns 32'h1 with no memory access. A job never changes the configuration registers.
- R3: The read and write channels carry a word index equal to the byte address shifted right by 6. A request is held with a stable index until `rd_valid` or `wr_ack` is seen.
- R4: Byte k of a memory word sits in bits [8k+7:8k]. The data for byte address A is taken from the fetched word starting at byte A[5:0], with the first byte in the lowest bits.
- R5: Encrypt and decrypt send the 8-byte blocks to the engine in ascending address order. `cph_dec` is 0 for encrypt and 1 for decrypt. Each engine result goes to the output slot given by its output byte address.
- R6: For encrypt or decrypt, a byte count that is not a multiple of 8 returns 32'h2. An input or output address that is not 8-byte aligned returns 32'h3. Either error raises `done` on the next edge, with no read and no write.
- R7: An output word is written only once all of its blocks are done, or when the job's last block is done. `wr_strb` marks exactly the bytes produced, and unwritten bytes are zero.
- R8: Set-key reads the word at the input address. It presents the `byte_cnt` key bytes from that offset on `key_bytes`, with all higher bytes zero, and `key_len`. Only then does it pulse `key_start`. It returns 32'h0 only after `key_done`.
- R9: Set-key with a byte count of 0, a count above KEY_MAX, or a range that runs past the end of the fetched word returns 32'h2 on the next edge, with no read.
- R10: Encrypt or decrypt with a byte count of 0 returns 32'h0 on the next edge, with no memory traffic.
- R11: Consecutive blocks in the same input word are fetched with a single read.
- R12: `done` is a one-cycle pulse, and `retc` holds its value until the next job completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Descriptor valid pulse, accepted in idle |
| flags | input | 32 | Control flags; zero selects discovery |
| in_addr | input | ADDR_W | Input byte address |
| out_addr | input | ADDR_W | Output byte address |
| byte_cnt | input | CNT_W | Byte count |
| mode | input | MODE_W | Job select: 0 key, 1 encrypt, 2 decrypt |
| done | output | 1 | Completion pulse |
| retc | output | 32 | Completion code |
| cfg_type | output | 32 | Configuration register: type code |
| cfg_rev | output | 32 | Configuration register: release level |
| rd_req | output | 1 | Read request, held until rd_valid |
| rd_idx | output | ADDR_W-6 | Read word index |
| rd_valid | input | 1 | Read data valid, ends the request |
| rd_data | input | WORD_W | Read word |
| wr_req | output | 1 | Write request, held until wr_ack |
| wr_idx | output | ADDR_W-6 | Write word index |
| wr_data | output | WORD_W | Write word |
| wr_strb | output | WORD_W/8 | Byte enables |
| wr_ack | input | 1 | Write accepted |
| cph_start | output | 1 | Cipher engine start pulse |
| cph_dec | output | 1 | Cipher direction, 1 for decrypt |
| cph_in | output | BLK_W | Block to the engine |
| cph_done | input | 1 | Engine result valid |
| cph_out | input | BLK_W | Engine result |
| key_start | output | 1 | Key sequencer start pulse |
| key_bytes | output | WORD_W | Extracted key, zero filled |
| key_len | output | 7 | Key length in bytes |
| key_done | input | 1 | Key sequencer finished |

## Verification
Discovery and every rejected descriptor complete on the first clock edge after the start edge. The bench therefore drives `start` at a falling edge and reads `done` and `retc` at the very next falling edge, with the read and write tallies unchanged. Memory, engine and sequencer responses come from bench models that act on falling edges. Read data arrives two cycles after the request, a write is logged and acknowledged one cycle after it appears, the engine answers three cycles after its start, and the sequencer four cycles after. Longer jobs are followed until their `done` pulse. Only then are the logged word indices, data, strobes and read counts compared with values computed from the memory pattern.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KFETCH,
      ST_KSTART,
      ST_KWAIT,
      ST_BFETCH,
      ST_CSTART,
      ST_CWAIT,
      ST_FLUSH
   } dsp_st_e;

   localparam logic [31:0] RC_OK        = 32'h0000_0000;
   localparam logic [31:0] RC_BAD_MODE  = 32'h0000_0001;
   localparam logic [31:0] RC_BAD_LEN   = 32'h0000_0002;
   localparam logic [31:0] RC_BAD_ALIGN = 32'h0000_0003;
   localparam logic [31:0] RC_DISCOVER  = 32'h0000_E00F;

   localparam int unsigned MODE_KEY = 0;
   localparam int unsigned MODE_ENC = 1;
   localparam int unsigned MODE_DEC = 2;

endpackage

// File: rtl/dsp_extract.sv
module dsp_extract #(
   parameter int WORD_W = 512,
   parameter int OFS_W  = 6
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [WORD_W-1:0] data_o
);

   // byte lane k of the word lives in bits [8k+7:8k]; shift the wanted byte down to lane 0
   assign data_o = word_i >> {ofs_i, 3'b000};

endmodule

// File: rtl/dsp_keymask.sv
module dsp_keymask #(
   parameter int WORD_W = 512,
   parameter int LEN_W  = 7
) (
   input  logic [WORD_W-1:0] data_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic [WORD_W-1:0] data_o
);

   localparam int NBYTES = WORD_W / 8;

   for (genvar k = 0; k < NBYTES; k++) begin : g_lane
      assign data_o[8*k +: 8] = (k < int'(len_i)) ? data_i[8*k +: 8] : 8'h00;
   end

endmodule

// File: rtl/dsp_wpack.sv
module dsp_wpack #(
   parameter int WORD_W = 512,
   parameter int BLK_W  = 64,
   localparam int SLOTS  = WORD_W / BLK_W,
   localparam int SLOT_W = $clog2(SLOTS),
   localparam int BBYTES = BLK_W / 8
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  clr,
   input  logic                  wen,
   input  logic [SLOT_W-1:0]     slot,
   input  logic [BLK_W-1:0]      blk,
   output logic [WORD_W-1:0]     data_o,
   output logic [WORD_W/8-1:0]   strb_o
);

   logic [BLK_W-1:0] slot_q [SLOTS];
   logic             used_q [SLOTS];

   always_ff @(posedge clk) begin
      for (int s = 0; s < SLOTS; s++) begin
         if (rst || clr) begin
            slot_q[s] <= '0;
            used_q[s] <= 1'b0;
         end else if (wen && slot == SLOT_W'(s)) begin
            slot_q[s] <= blk;
            used_q[s] <= 1'b1;
         end
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_out
      assign data_o[s*BLK_W +: BLK_W]   = slot_q[s];
      assign strb_o[s*BBYTES +: BBYTES] = {BBYTES{used_q[s]}};
   end

endmodule

// File: rtl/acc_job_dispatch.sv
module acc_job_dispatch
   import dsp_pkg::*;
#(
   parameter int          ADDR_W    = 64,
   parameter int          CNT_W     = 32,
   parameter int          MODE_W    = 8,
   parameter int          WORD_W    = 512,
   parameter int          BLK_W     = 64,
   parameter int          KEY_MAX   = 56,
   parameter logic [31:0] TYPE_CODE = 32'h10C1_0001,
   parameter logic [31:0] REL_LEVEL = 32'h0000_0003,
   localparam int WORD_BYTES = WORD_W / 8,
   localparam int OFS_W      = $clog2(WORD_BYTES),
   localparam int IDX_W      = ADDR_W - OFS_W,
   localparam int KLEN_W     = $clog2(WORD_BYTES) + 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  start,
   input  logic [31:0]           flags,
   input  logic [ADDR_W-1:0]     in_addr,
   input  logic [ADDR_W-1:0]     out_addr,
   input  logic [CNT_W-1:0]      byte_cnt,
   input  logic [MODE_W-1:0]     mode,
   output logic                  done,
   output logic [31:0]           retc,
   output logic [31:0]           cfg_type,
   output logic [31:0]           cfg_rev,
   output logic                  rd_req,
   output logic [IDX_W-1:0]      rd_idx,
   input  logic                  rd_valid,
   input  logic [WORD_W-1:0]     rd_data,
   output logic                  wr_req,
   output logic [IDX_W-1:0]      wr_idx,
   output logic [WORD_W-1:0]     wr_data,
   output logic [WORD_BYTES-1:0] wr_strb,
   input  logic                  wr_ack,
   output logic                  cph_start,
   output logic                  cph_dec,
   output logic [BLK_W-1:0]      cph_in,
   input  logic                  cph_done,
   input  logic [BLK_W-1:0]      cph_out,
   output logic                  key_start,
   output logic [WORD_W-1:0]     key_bytes,
   output logic [KLEN_W-1:0]     key_len,
   input  logic                  key_done
);

   localparam int BLK_BYTES = BLK_W / 8;
   localparam int BOFS_W    = $clog2(BLK_BYTES);
   localparam int SLOTS     = WORD_W / BLK_W;

   // elaboration-time geometry checks
   if (WORD_W % BLK_W != 0 || BLK_W % 8 != 0) begin : g_bad_geom
      $error("word width must be a whole number of byte-wide blocks");
   end
   if ((1 << OFS_W) != WORD_BYTES || (1 << BOFS_W) != BLK_BYTES || SLOTS < 2) begin : g_bad_pow2
      $error("word and block sizes must be powers of two with at least two blocks per word");
   end
   if (KEY_MAX < 1 || KEY_MAX > WORD_BYTES) begin : g_bad_key
      $error("KEY_MAX must lie within one word");
   end
   if (ADDR_W <= OFS_W || CNT_W < KLEN_W) begin : g_bad_addr
      $error("address or count width too small");
   end

   dsp_st_e               st_q;
   logic [ADDR_W-1:0]     cur_in_q, cur_out_q;
   logic [CNT_W-1:0]      left_q;
   logic                  dec_q, last_q, cache_ok_q;
   logic [IDX_W-1:0]      cache_idx_q, flush_idx_q;
   logic [WORD_W-1:0]     cache_word_q, ext_word;
   logic [KLEN_W-1:0]     klen_q;
   logic                  done_q;
   logic [31:0]           retc_q, cfg_type_q, cfg_rev_q;

   // descriptor decode (used in idle only)
   logic                  is_disc, len_blk_ok, align_ok, key_ok, cnt_zero;
   logic [CNT_W:0]        key_end;
   assign is_disc    = (flags == 32'd0);
   assign cnt_zero   = (byte_cnt == '0);
   assign len_blk_ok = (byte_cnt[BOFS_W-1:0] == '0);
   assign align_ok   = (in_addr[BOFS_W-1:0] == '0) && (out_addr[BOFS_W-1:0] == '0);
   assign key_end    = {1'b0, byte_cnt} + (CNT_W+1)'(in_addr[OFS_W-1:0]);
   assign key_ok     = !cnt_zero && (byte_cnt <= CNT_W'(KEY_MAX))
                       && (key_end <= (CNT_W+1)'(WORD_BYTES));

   // datapath helpers
   logic                  hit, out_slot_last, blk_last;
   logic [IDX_W-1:0]      in_word, out_word;
   assign in_word       = cur_in_q[ADDR_W-1:OFS_W];
   assign out_word      = cur_out_q[ADDR_W-1:OFS_W];
   assign hit           = cache_ok_q && (cache_idx_q == in_word);
   assign out_slot_last = &cur_out_q[OFS_W-1:BOFS_W];
   assign blk_last      = (left_q == CNT_W'(BLK_BYTES));

   dsp_extract #(.WORD_W(WORD_W), .OFS_W(OFS_W)) u_ext (
      .word_i (cache_word_q),
      .ofs_i  (cur_in_q[OFS_W-1:0]),
      .data_o (ext_word)
   );

   dsp_keymask #(.WORD_W(WORD_W), .LEN_W(KLEN_W)) u_kmask (
      .data_i (ext_word),
      .len_i  (klen_q),
      .data_o (key_bytes)
   );

   logic pack_wen, pack_clr;
   assign pack_wen = (st_q == ST_CWAIT) && cph_done;
   assign pack_clr = (st_q == ST_FLUSH) && wr_ack;

   dsp_wpack #(.WORD_W(WORD_W), .BLK_W(BLK_W)) u_pack (
      .clk    (clk),
      .rst    (rst),
      .clr    (pack_clr),
      .wen    (pack_wen),
      .slot   (cur_out_q[OFS_W-1:BOFS_W]),
      .blk    (cph_out),
      .data_o (wr_data),
      .strb_o (wr_strb)
   );

   // sequencer
   always_ff @(posedge clk) begin
      if (rst) begin
         st_q         <= ST_IDLE;
         cur_in_q     <= '0;
         cur_out_q    <= '0;
         left_q       <= '0;
         dec_q        <= 1'b0;
         last_q       <= 1'b0;
         cache_ok_q   <= 1'b0;
         cache_idx_q  <= '0;
         cache_word_q <= '0;
         flush_idx_q  <= '0;
         klen_q       <= '0;
         done_q       <= 1'b0;
         retc_q       <= '0;
         cfg_type_q   <= '0;
         cfg_rev_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               cur_in_q   <= in_addr;
               cur_out_q  <= out_addr;
               left_q     <= byte_cnt;
               cache_ok_q <= 1'b0;
               dec_q      <= (mode == MODE_W'(MODE_DEC));
               if (is_disc) begin
                  cfg_type_q <= TYPE_CODE;
                  cfg_rev_q  <= REL_LEVEL;
                  retc_q     <= RC_DISCOVER;
                  done_q     <= 1'b1;
               end else if (mode == MODE_W'(MODE_KEY)) begin
                  if (key_ok) begin
                     klen_q <= byte_cnt[KLEN_W-1:0];
                     st_q   <= ST_KFETCH;
                  end else begin
                     retc_q <= RC_BAD_LEN;
                     done_q <= 1'b1;
                  end
               end else if (mode == MODE_W'(MODE_ENC) || mode == MODE_W'(MODE_DEC)) begin
                  if (!len_blk_ok) begin
                     retc_q <= RC_BAD_LEN;
                     done_q <= 1'b1;
                  end else if (!align_ok) begin
                     retc_q <= RC_BAD_ALIGN;
                     done_q <= 1'b1;
                  end else if (cnt_zero) begin
                     retc_q <= RC_OK;
                     done_q <= 1'b1;
                  end else begin
                     st_q <= ST_BFETCH;
                  end
               end else begin
                  retc_q <= RC_BAD_MODE;
                  done_q <= 1'b1;
               end
            end
            ST_KFETCH: if (rd_valid) begin
               cache_word_q <= rd_data;
               st_q         <= ST_KSTART;
            end
            ST_KSTART: st_q <= ST_KWAIT;
            ST_KWAIT: if (key_done) begin
               retc_q <= RC_OK;
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            ST_BFETCH: begin
               if (hit) begin
                  st_q <= ST_CSTART;
               end else if (rd_valid) begin
                  cache_word_q <= rd_data;
                  cache_idx_q  <= in_word;
                  cache_ok_q   <= 1'b1;
                  st_q         <= ST_CSTART;
               end
            end
            ST_CSTART: st_q <= ST_CWAIT;
            ST_CWAIT: if (cph_done) begin
               flush_idx_q <= out_word;
               last_q      <= blk_last;
               cur_in_q    <= cur_in_q + ADDR_W'(BLK_BYTES);
               cur_out_q   <= cur_out_q + ADDR_W'(BLK_BYTES);
               left_q      <= left_q - CNT_W'(BLK_BYTES);
               st_q        <= (blk_last || out_slot_last) ? ST_FLUSH : ST_BFETCH;
            end
            ST_FLUSH: if (wr_ack) begin
               if (last_q) begin
                  retc_q <= RC_OK;
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else begin
                  st_q <= ST_BFETCH;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   logic idle_w;
   assign idle_w    = (st_q == ST_IDLE);

   assign rd_req    = (st_q == ST_KFETCH) || (st_q == ST_BFETCH && !hit);
   assign rd_idx    = in_word;
   assign wr_req    = (st_q == ST_FLUSH);
   assign wr_idx    = flush_idx_q;
   assign cph_start = (st_q == ST_CSTART);
   assign cph_dec   = dec_q;
   assign cph_in    = ext_word[BLK_W-1:0];
   assign key_start = (st_q == ST_KSTART);
   assign key_len   = klen_q;
   assign done      = done_q;
   assign retc      = retc_q;
   assign cfg_type  = cfg_type_q;
   assign cfg_rev   = cfg_rev_q;

endmodule

// File: rtl/dsp_chk.sv
module dsp_chk #(
   parameter int IDX_W  = 58,
   parameter int CNT_W  = 32,
   parameter int MODE_W = 8,
   parameter int WORD_W = 512
) (
   input logic                clk,
   input logic                rst,
   input logic                idle_w,
   input logic                start,
   input logic [31:0]         flags,
   input logic [CNT_W-1:0]    byte_cnt,
   input logic [MODE_W-1:0]   mode,
   input logic                done,
   input logic [31:0]         retc,
   input logic [31:0]         cfg_type,
   input logic [31:0]         cfg_rev,
   input logic                rd_req,
   input logic [IDX_W-1:0]    rd_idx,
   input logic                rd_valid,
   input logic                wr_req,
   input logic [IDX_W-1:0]    wr_idx,
   input logic [WORD_W-1:0]   wr_data,
   input logic [WORD_W/8-1:0] wr_strb,
   input logic                wr_ack,
   input logic                cph_start,
   input logic                key_start
);

   logic disc_go, blk_len_bad;
   assign disc_go     = start && idle_w && (flags == 32'd0);
   assign blk_len_bad = start && idle_w && (flags != 32'd0) && (byte_cnt[2:0] != 3'd0)
                        && (mode == MODE_W'(1) || mode == MODE_W'(2));

   AST_DISC_RESP: assert property (@(posedge clk) disable iff (rst)
      disc_go |=> (done && retc == 32'hE00F));                                    // R1
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !disc_go |=> ($stable(cfg_type) && $stable(cfg_rev)));                      // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      idle_w |-> (!rd_req && !wr_req && !cph_start && !key_start));               // R2
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
      (rd_req && !rd_valid) |=> (rd_req && $stable(rd_idx)));                     // R3
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
      (wr_req && !wr_ack) |=> (wr_req && $stable(wr_idx) && $stable(wr_data)
                               && $stable(wr_strb)));                             // R3
   AST_LEN_REJECT: assert property (@(posedge clk) disable iff (rst)
      blk_len_bad |=> (done && retc == 32'h2 && !rd_req && !wr_req));             // R6
   AST_STRB_NZ: assert property (@(posedge clk) disable iff (rst)
      wr_req |-> (wr_strb != '0));                                                // R7
   AST_ONE_ENGINE: assert property (@(posedge clk) disable iff (rst)
      !(cph_start && key_start));                                                 // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);                                                            // R12

endmodule

bind acc_job_dispatch dsp_chk #(
   .IDX_W(IDX_W), .CNT_W(CNT_W), .MODE_W(MODE_W), .WORD_W(WORD_W)
) u_chk (
   .clk(clk), .rst(rst), .idle_w(idle_w), .start(start), .flags(flags),
   .byte_cnt(byte_cnt), .mode(mode), .done(done), .retc(retc),
   .cfg_type(cfg_type), .cfg_rev(cfg_rev), .rd_req(rd_req), .rd_idx(rd_idx),
   .rd_valid(rd_valid), .wr_req(wr_req), .wr_idx(wr_idx), .wr_data(wr_data),
   .wr_strb(wr_strb), .wr_ack(wr_ack), .cph_start(cph_start), .key_start(key_start)
);

// File: tb/sim_acc_job_dispatch.sv
`timescale 1ns/1ps
module sim_acc_job_dispatch;

   localparam logic [63:0] K_ENC = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] K_DEC = 64'hA5C3_5A3C_F00F_1EE1;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst, start;
   logic [31:0]   flags;
   logic [63:0]   in_addr, out_addr;
   logic [31:0]   byte_cnt;
   logic [7:0]    mode;
   logic          done;
   logic [31:0]   retc, cfg_type, cfg_rev;
   logic          rd_req, rd_valid;
   logic [57:0]   rd_idx, wr_idx;
   logic [511:0]  rd_data, wr_data, key_bytes;
   logic [63:0]   wr_strb;
   logic          wr_req, wr_ack;
   logic          cph_start, cph_dec, cph_done;
   logic [63:0]   cph_in, cph_out;
   logic          key_start, key_done;
   logic [6:0]    key_len;

   acc_job_dispatch u0 (
      .clk(clk), .rst(rst), .start(start), .flags(flags), .in_addr(in_addr),
      .out_addr(out_addr), .byte_cnt(byte_cnt), .mode(mode), .done(done),
      .retc(retc), .cfg_type(cfg_type), .cfg_rev(cfg_rev), .rd_req(rd_req),
      .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data), .wr_req(wr_req),
      .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb), .wr_ack(wr_ack),
      .cph_start(cph_start), .cph_dec(cph_dec), .cph_in(cph_in),
      .cph_done(cph_done), .cph_out(cph_out), .key_start(key_start),
      .key_bytes(key_bytes), .key_len(key_len), .key_done(key_done)
   );

   int n_tests = 0, n_fail = 0;
   int n_rd = 0, n_wr = 0, n_key = 0;
   bit key_seen = 1'b0;
   logic [57:0]  rd_log [8];
   logic [57:0]  wr_log_idx [8];
   logic [511:0] wr_log_dat [8];
   logic [63:0]  wr_log_stb [8];

   function automatic logic [7:0] mbyte(input logic [63:0] a);
      return a[7:0] * 8'd37 + 8'd11;
   endfunction

   function automatic logic [511:0] mword(input logic [57:0] idx);
      logic [511:0] w;
      for (int k = 0; k < 64; k++) w[8*k +: 8] = mbyte({idx, 6'd0} + 64'(k));
      return w;
   endfunction

   function automatic logic [63:0] mblk(input logic [63:0] a);
      logic [63:0] b;
      for (int k = 0; k < 8; k++) b[8*k +: 8] = mbyte(a + 64'(k));
      return b;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [511:0] act, input logic [511:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // read channel model: data two cycles after the request
   initial begin
      int wait_c = 0;
      rd_valid = 1'b0;
      rd_data  = '0;
      forever begin
         @(negedge clk);
         if (rd_valid) begin
            rd_valid = 1'b0;
            wait_c   = 0;
         end else if (rd_req) begin
            wait_c++;
            if (wait_c == 2) begin
               rd_data  = mword(rd_idx);
               rd_valid = 1'b1;
               if (n_rd < 8) rd_log[n_rd] = rd_idx;
               n_rd++;
            end
         end
      end
   end

   // write channel model: log and acknowledge
   initial begin
      wr_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (wr_ack) wr_ack = 1'b0;
         else if (wr_req) begin
            if (n_wr < 8) begin
               wr_log_idx[n_wr] = wr_idx;
               wr_log_dat[n_wr] = wr_data;
               wr_log_stb[n_wr] = wr_strb;
            end
            n_wr++;
            wr_ack = 1'b1;
         end
      end
   end

   // cipher engine model: xor with a direction-dependent constant, three cycles
   initial begin
      int cnt = 0;
      logic [63:0] held;
      cph_done = 1'b0;
      cph_out  = '0;
      held     = '0;
      forever begin
         @(negedge clk);
         cph_done = 1'b0;
         if (cph_start) begin
            held = cph_in ^ (cph_dec ? K_DEC : K_ENC);
            cnt  = 3;
         end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               cph_out  = held;
               cph_done = 1'b1;
            end
         end
      end
   end

   // key sequencer model: done four cycles after start
   initial begin
      int cnt = 0;
      key_done = 1'b0;
      forever begin
         @(negedge clk);
         key_done = 1'b0;
         if (key_start) begin
            n_key++;
            cnt = 4;
         end else if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               key_done = 1'b1;
               key_seen = 1'b1;
            end
         end
      end
   end

   task automatic run_job(input logic [31:0] f, input logic [7:0] m, input logic [31:0] c,
                          input logic [63:0] ia, input logic [63:0] oa, output int cyc);
      n_rd = 0; n_wr = 0; n_key = 0; key_seen = 1'b0;
      @(negedge clk);
      flags = f; mode = m; byte_cnt = c; in_addr = ia; out_addr = oa;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!done && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   typedef struct packed {
      logic [31:0] flg;
      logic [7:0]  md;
      logic [31:0] cnt;
      logic [63:0] ia;
      logic [63:0] oa;
      logic [31:0] rc;
   } vec_t;

   // descriptors that finish on the first edge
   localparam vec_t VEC [10] = '{
      '{32'd1, 8'd3, 32'd8,  64'h0,   64'h0,   32'h1},     // R2 unknown mode
      '{32'd1, 8'd1, 32'd12, 64'h0,   64'h40,  32'h2},     // R6 ragged length
      '{32'd5, 8'd2, 32'd7,  64'h80,  64'h0,   32'h2},     // R6
      '{32'd1, 8'd1, 32'd16, 64'h44,  64'h0,   32'h3},     // R6 input misaligned
      '{32'd1, 8'd2, 32'd8,  64'h0,   64'h3,   32'h3},     // R6 output misaligned
      '{32'd1, 8'd1, 32'd0,  64'h0,   64'h0,   32'h0},     // R10 empty job
      '{32'd1, 8'd0, 32'd0,  64'h0,   64'h0,   32'h2},     // R9 empty key
      '{32'd1, 8'd0, 32'd57, 64'h0,   64'h0,   32'h2},     // R9 key too long
      '{32'd1, 8'd0, 32'd8,  64'h3C,  64'h0,   32'h2},     // R9 key crosses word
      '{32'd0, 8'd1, 32'd8,  64'h0,   64'h0,   32'hE00F}   // R1 discovery wins over mode
   };

   initial begin
      int cyc;
      logic [511:0] exp_w;
      rst = 1'b1; start = 1'b0; flags = '0; mode = '0; byte_cnt = '0;
      in_addr = '0; out_addr = '0;
      repeat (4) @(negedge clk);
      chk(done == 1'b0 && retc == 32'd0, "R12", "reset done/retc", {done, retc}, '0);
      chk(cfg_type == 32'd0 && cfg_rev == 32'd0, "R1", "reset cfg", {cfg_type, cfg_rev}, '0);
      chk(!rd_req && !wr_req, "R3", "reset requests", {rd_req, wr_req}, '0);
      rst = 1'b0;

      foreach (VEC[i]) begin
         run_job(VEC[i].flg, VEC[i].md, VEC[i].cnt, VEC[i].ia, VEC[i].oa, cyc);
         chk(cyc == 1 && done, "R6", $sformatf("vec %0d done cycle", i), 512'(cyc), 512'd1);
         chk(retc == VEC[i].rc, "R2", $sformatf("vec %0d retc", i), 512'(retc), 512'(VEC[i].rc));
         chk(n_rd == 0 && n_wr == 0, "R6", $sformatf("vec %0d traffic", i),
             512'(n_rd + n_wr), 512'd0);
         @(negedge clk);
         chk(!done, "R12", $sformatf("vec %0d done pulse", i), 512'(done), 512'd0);
      end
      chk(cfg_type == 32'h10C1_0001 && cfg_rev == 32'h3, "R1", "cfg after discovery",
          {cfg_type, cfg_rev}, {32'h10C1_0001, 32'h3});

      // R5 R7 R11: encrypt 24 bytes, one input word, output spans two words
      run_job(32'd1, 8'd1, 32'd24, 64'h48, 64'h1B0, cyc);
      chk(retc == 32'd0, "R5", "encrypt retc", 512'(retc), 512'd0);
      chk(n_rd == 1 && rd_log[0] == 58'd1, "R11", "encrypt single fetch",
          {n_rd, 32'(rd_log[0])}, {32'd1, 32'd1});
      chk(n_wr == 2, "R7", "encrypt write count", 512'(n_wr), 512'd2);
      exp_w = '0;
      exp_w[48*8 +: 64] = mblk(64'h48) ^ K_ENC;
      exp_w[56*8 +: 64] = mblk(64'h50) ^ K_ENC;
      chk(wr_log_idx[0] == 58'd6 && wr_log_stb[0] == 64'hFFFF_0000_0000_0000, "R3",
          "encrypt first word index/strobe", {wr_log_idx[0], wr_log_stb[0]},
          {58'd6, 64'hFFFF_0000_0000_0000});
      chk(wr_log_dat[0] == exp_w, "R4", "encrypt first word data", wr_log_dat[0], exp_w);
      exp_w = '0;
      exp_w[63:0] = mblk(64'h58) ^ K_ENC;
      chk(wr_log_idx[1] == 58'd7 && wr_log_stb[1] == 64'hFF, "R7",
          "encrypt final partial word", {wr_log_idx[1], wr_log_stb[1]}, {58'd7, 64'hFF});
      chk(wr_log_dat[1] == exp_w, "R5", "encrypt final data", wr_log_dat[1], exp_w);

      // R5 R4: decrypt 16 bytes straddling an input word boundary
      run_job(32'd3, 8'd2, 32'd16, 64'h38, 64'h0, cyc);
      chk(retc == 32'd0 && n_rd == 2 && rd_log[0] == 58'd0 && rd_log[1] == 58'd1, "R4",
          "decrypt fetch order", {retc, n_rd}, {32'd0, 32'd2});
      exp_w = '0;
      exp_w[63:0]   = mblk(64'h38) ^ K_DEC;
      exp_w[127:64] = mblk(64'h40) ^ K_DEC;
      chk(n_wr == 1 && wr_log_idx[0] == 58'd0 && wr_log_stb[0] == 64'hFFFF, "R7",
          "decrypt write", {n_wr, wr_log_stb[0]}, {32'd1, 64'hFFFF});
      chk(wr_log_dat[0] == exp_w, "R5", "decrypt data", wr_log_dat[0], exp_w);

      // R8: key of 5 bytes at an unaligned address
      run_job(32'd1, 8'd0, 32'd5, 64'h23, 64'h0, cyc);
      exp_w = '0;
      for (int k = 0; k < 5; k++) exp_w[8*k +: 8] = mbyte(64'h23 + 64'(k));
      chk(retc == 32'd0 && key_seen && n_key == 1, "R8", "key done before completion",
          {retc, 32'(key_seen), 32'(n_key)}, {32'd0, 32'd1, 32'd1});
      chk(key_bytes == exp_w && key_len == 7'd5, "R8", "key bytes", key_bytes, exp_w);
      chk(n_rd == 1 && rd_log[0] == 58'd0 && n_wr == 0, "R3", "key read index",
          {n_rd, n_wr}, {32'd1, 32'd0});
      chk(cfg_type == 32'h10C1_0001, "R2", "cfg unchanged by jobs", 512'(cfg_type),
          512'h10C1_0001);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R12 watchdog: actual no completion expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule